// File: doc/BRIEF.md
# Readout Protection Level Controller

This block keeps a three-step protection level for a microcontroller's debug and readout paths and enforces it cycle by cycle. At reset it decodes the level from a stored option word. While running it accepts level-change requests from a programming interface, and it reports each new level back to non-volatile storage as an encoded word. Level changes are asymmetric. A request to raise the level always succeeds. Lowering from the middle level to the open level first requires a mass erase, which an external erase engine performs and acknowledges. The top level can never be left.

Every memory access is presented with its source (debug path or CPU), its target (flash, protected SRAM or other memory), its operation and the current boot mode. The block grants or refuses the access in the same cycle, and it raises a bus error for a refused read. It also drives the enables for the debug port, the trace outputs and boundary scan, and it freezes all option-word writes at the top level. Only two option patterns are treated as special. Every other pattern is read as the middle level, so a damaged option word fails safe.

Top module: `rdp_ctrl`

## Requirements
- R1: During reset the level is loaded from `opt_word_i`. Pattern LVL0_PAT (default 8'hAA) gives level 0, pattern LVL2_PAT (default 8'hCC) gives level 2, and any other pattern gives level 1. `level_o` encodes the level as 0, 1 or 2. After reset no erase is requested and no ack or error pulse is asserted.
- R2: At level 0, with no erase in progress, every valid access is granted, whatever its source, target, operation or boot mode.
- R3: At level 1 or 2, a valid access to flash (target 0) or to protected SRAM (target 1) is granted only when it comes from the CPU (`acc_dbg_i`=0) and the boot mode is flash (`boot_mode_i`=0). Otherwise it is refused. At level 1, accesses to the other targets (2, 3) are granted.
- R4: A refused read (`acc_op_i`=0) asserts `acc_buserr_o` together with `acc_deny_o`. A refused program (1) or erase (2, 3) asserts only `acc_deny_o`. When `acc_valid_i` is low, grant, deny and bus error are all low.
- R5: At level 2, every debug-source access is refused whatever its target. The debug port, trace and boundary-scan enables are low at level 2 and high at levels 0 and 1.
- R6: An option write request is granted (`opt_wr_ok_o`) at levels 0 and 1 when no erase is in progress. It is refused (`opt_wr_deny_o`) at level 2 and during an erase.
- R7: A change request (`chg_level_i` 0 to 2) for a level above the current one is accepted. In the next cycle `level_o` shows the new level, and `chg_ack_o` and `nv_wr_o` pulse for one cycle with `nv_word_o` set to the new level's pattern (LVL0_PAT, LVL1_PAT default 8'hFF, or LVL2_PAT).
- R8: A request for level 0 while at level 1 raises `erase_req_o` from the next cycle, and the level stays 1. The level changes only after `erase_done_i` is seen during the erase. In the cycle after that, `level_o` becomes 0, `erase_req_o` drops, and `chg_ack_o` and `nv_wr_o` pulse with `nv_word_o` = LVL0_PAT.
- R9: While `erase_req_o` is high, every valid access is refused, and refused reads also raise a bus error.
- R10: At level 2, every change request is rejected. `chg_err_o` pulses in the next cycle, and the level stays 2.
- R11: A request with `chg_level_i`=3, a request for the current level, and any request made during an erase are rejected. `chg_err_o` pulses for one cycle, the level and erase state are unchanged, and `nv_wr_o` stays low.
- R12: `erase_done_i` has no effect when no erase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; level loaded from option word |
| opt_word_i | input | OPT_W | Stored protection option word |
| chg_req_i | input | 1 | Level-change request strobe |
| chg_level_i | input | 2 | Requested level (3 is invalid) |
| chg_ack_o | output | 1 | One-cycle pulse: level change committed |
| chg_err_o | output | 1 | One-cycle pulse: request rejected |
| nv_wr_o | output | 1 | One-cycle pulse: write nv_word_o to storage |
| nv_word_o | output | OPT_W | Encoded pattern of the committed level |
| erase_req_o | output | 1 | Mass erase requested (held until done) |
| erase_done_i | input | 1 | Erase engine completion |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_dbg_i | input | 1 | 1 = debug path, 0 = CPU |
| acc_tgt_i | input | 2 | 0 flash, 1 protected SRAM, 2/3 other |
| acc_op_i | input | 2 | 0 read, 1 program, 2/3 erase |
| boot_mode_i | input | 2 | 0 flash, 1 SRAM, 2 system loader, 3 other |
| acc_grant_o | output | 1 | Access allowed |
| acc_deny_o | output | 1 | Access refused |
| acc_buserr_o | output | 1 | Bus error for a refused read |
| opt_wr_req_i | input | 1 | Option word write request |
| opt_wr_ok_o | output | 1 | Option write allowed |
| opt_wr_deny_o | output | 1 | Option write refused |
| dbg_port_en_o | output | 1 | Debug port enable |
| trace_en_o | output | 1 | Trace output enable |
| bscan_en_o | output | 1 | Boundary-scan enable |
| level_o | output | 2 | Current level |

## Verification
The bench builds the block with its default parameters: an 8-bit option word and the patterns 8'hAA, 8'hFF and 8'hCC. With these values the bench can drive, at reset, the two special patterns, a corrupted word and arbitrary random words. Frequent random resets bring each level back often, so raises, erase-gated regressions and the lock at level 2 are all revisited many times. Erase completions arrive at random, so erases of varied length are exercised, as are change requests and stray completions that land inside or outside an erase.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'd0,
        LVL_GUARD = 2'd1,
        LVL_LOCK  = 2'd2
    } prot_lvl_e;

    typedef enum logic [1:0] {
        TGT_FLASH = 2'd0,
        TGT_PSRAM = 2'd1,
        TGT_MISC0 = 2'd2,
        TGT_MISC1 = 2'd3
    } acc_tgt_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_ERX   = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        BOOT_FLASH = 2'd0,
        BOOT_SRAM  = 2'd1,
        BOOT_SYS   = 2'd2,
        BOOT_OTHER = 2'd3
    } boot_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ERASE = 1'b1
    } ctl_st_e;

    typedef struct packed {
        logic     valid;
        logic     from_dbg;
        acc_tgt_e tgt;
        acc_op_e  op;
        boot_e    boot;
    } acc_req_t;

    typedef struct packed {
        logic grant;
        logic deny;
        logic buserr;
    } acc_rsp_t;

    localparam int NUM_DBG_EN = 3;

    function automatic logic tgt_is_guarded(input acc_tgt_e t);
        return (t == TGT_FLASH) || (t == TGT_PSRAM);
    endfunction

    function automatic logic code_is_level(input logic [1:0] c);
        return c != 2'd3;
    endfunction

endpackage

// File: rtl/rdp_level_fsm.sv
module rdp_level_fsm
    import rdp_pkg::*;
#(
    parameter int               OPT_W    = 8,
    parameter logic [OPT_W-1:0] LVL0_PAT = 8'hAA,
    parameter logic [OPT_W-1:0] LVL1_PAT = 8'hFF,
    parameter logic [OPT_W-1:0] LVL2_PAT = 8'hCC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPT_W-1:0] opt_word_i,
    input  logic             chg_req_i,
    input  logic [1:0]       chg_lvl_i,
    input  logic             erase_done_i,
    output prot_lvl_e        lvl_o,
    output logic             erasing_o,
    output logic             chg_ack_o,
    output logic             chg_err_o,
    output logic             nv_wr_o,
    output logic [OPT_W-1:0] nv_word_o
);

    function automatic prot_lvl_e decode_word(input logic [OPT_W-1:0] w);
        if (w == LVL0_PAT) return LVL_OPEN;
        if (w == LVL2_PAT) return LVL_LOCK;
        return LVL_GUARD;
    endfunction

    function automatic logic [OPT_W-1:0] encode_lvl(input prot_lvl_e l);
        case (l)
            LVL_OPEN: return LVL0_PAT;
            LVL_LOCK: return LVL2_PAT;
            default:  return LVL1_PAT;
        endcase
    endfunction

    prot_lvl_e        lvl_q, lvl_d;
    ctl_st_e          st_q, st_d;
    logic             ack_d, err_d, nvw_d;
    logic             ack_q, err_q, nvw_q;
    logic [OPT_W-1:0] word_q, word_d;
    prot_lvl_e        want;
    logic             want_ok, is_raise, is_regress;

    always_comb begin
        want_ok    = code_is_level(chg_lvl_i);
        want       = prot_lvl_e'(chg_lvl_i);
        is_raise   = want_ok && (chg_lvl_i > lvl_q);
        is_regress = want_ok && (lvl_q == LVL_GUARD) && (want == LVL_OPEN);
    end

    always_comb begin
        lvl_d  = lvl_q;
        st_d   = st_q;
        ack_d  = 1'b0;
        err_d  = 1'b0;
        nvw_d  = 1'b0;
        word_d = word_q;
        if (st_q == ST_ERASE) begin
            if (chg_req_i) err_d = 1'b1;
            if (erase_done_i) begin
                lvl_d  = LVL_OPEN;
                st_d   = ST_RUN;
                ack_d  = 1'b1;
                nvw_d  = 1'b1;
                word_d = encode_lvl(LVL_OPEN);
            end
        end else if (chg_req_i) begin
            if (is_raise) begin
                lvl_d  = want;
                ack_d  = 1'b1;
                nvw_d  = 1'b1;
                word_d = encode_lvl(want);
            end else if (is_regress) begin
                st_d = ST_ERASE;
            end else begin
                err_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= decode_word(opt_word_i);
            st_q   <= ST_RUN;
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            nvw_q  <= 1'b0;
            word_q <= '0;
        end else begin
            lvl_q  <= lvl_d;
            st_q   <= st_d;
            ack_q  <= ack_d;
            err_q  <= err_d;
            nvw_q  <= nvw_d;
            word_q <= word_d;
        end
    end

    assign lvl_o     = lvl_q;
    assign erasing_o = (st_q == ST_ERASE);
    assign chg_ack_o = ack_q;
    assign chg_err_o = err_q;
    assign nv_wr_o   = nvw_q;
    assign nv_word_o = word_q;

    // R10: the top level is never left
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
        lvl_q == LVL_LOCK |=> lvl_q == LVL_LOCK);

    // R8: level 1 reaches level 0 only through an acknowledged erase
    assert_erase_first_R8: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == LVL_GUARD && !(st_q == ST_ERASE && erase_done_i)) |=> lvl_q != LVL_OPEN);

    // R7: a raise is acknowledged and stored
    assert_raise_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && chg_req_i && chg_lvl_i != 2'd3 && chg_lvl_i > lvl_q)
        |=> (chg_ack_o && nv_wr_o));

    // R11: a reported rejection left the level unchanged
    assert_reject_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (chg_err_o && !chg_ack_o) |-> $stable(lvl_q));

endmodule

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
    import rdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  prot_lvl_e lvl_i,
    input  logic      erasing_i,
    input  acc_req_t  req_i,
    output acc_rsp_t  rsp_o
);

    logic guarded, allow;

    always_comb begin
        guarded = tgt_is_guarded(req_i.tgt);
        if (erasing_i) begin
            allow = 1'b0;
        end else if (lvl_i == LVL_OPEN) begin
            allow = 1'b1;
        end else if (lvl_i == LVL_LOCK && req_i.from_dbg) begin
            allow = 1'b0;
        end else if (guarded) begin
            allow = !req_i.from_dbg && (req_i.boot == BOOT_FLASH);
        end else begin
            allow = 1'b1;
        end
        rsp_o.grant  = req_i.valid && allow;
        rsp_o.deny   = req_i.valid && !allow;
        rsp_o.buserr = req_i.valid && !allow && (req_i.op == OP_READ);
    end

    // R3: debug-side reach into guarded memory is refused once protected
    assert_dbg_guarded_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && req_i.from_dbg && tgt_is_guarded(req_i.tgt) && lvl_i != LVL_OPEN)
        |-> rsp_o.deny);

    // R4: bus errors only for refused reads
    assert_buserr_read_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_o.buserr |-> (rsp_o.deny && req_i.op == OP_READ));

    // R5: no debug access at all at the top level
    assert_lock_dbg_R5: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && req_i.from_dbg && lvl_i == LVL_LOCK) |-> !rsp_o.grant);

    // R9: everything blocked during the erase
    assert_erase_block_R9: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && erasing_i) |-> rsp_o.deny);

endmodule

// File: rtl/rdp_debug_enables.sv
module rdp_debug_enables
    import rdp_pkg::*;
#(
    parameter int N_EN = NUM_DBG_EN
) (
    input  prot_lvl_e       lvl_i,
    output logic [N_EN-1:0] en_o
);

    genvar gi;
    generate
        for (gi = 0; gi < N_EN; gi++) begin : g_en
            assign en_o[gi] = (lvl_i != LVL_LOCK);
        end
    endgenerate

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
#(
    parameter int               OPT_W    = 8,
    parameter logic [OPT_W-1:0] LVL0_PAT = 8'hAA,
    parameter logic [OPT_W-1:0] LVL1_PAT = 8'hFF,
    parameter logic [OPT_W-1:0] LVL2_PAT = 8'hCC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPT_W-1:0] opt_word_i,
    input  logic             chg_req_i,
    input  logic [1:0]       chg_level_i,
    output logic             chg_ack_o,
    output logic             chg_err_o,
    output logic             nv_wr_o,
    output logic [OPT_W-1:0] nv_word_o,
    output logic             erase_req_o,
    input  logic             erase_done_i,
    input  logic             acc_valid_i,
    input  logic             acc_dbg_i,
    input  logic [1:0]       acc_tgt_i,
    input  logic [1:0]       acc_op_i,
    input  logic [1:0]       boot_mode_i,
    output logic             acc_grant_o,
    output logic             acc_deny_o,
    output logic             acc_buserr_o,
    input  logic             opt_wr_req_i,
    output logic             opt_wr_ok_o,
    output logic             opt_wr_deny_o,
    output logic             dbg_port_en_o,
    output logic             trace_en_o,
    output logic             bscan_en_o,
    output logic [1:0]       level_o
);

    localparam int EN_DBG   = 0;
    localparam int EN_TRACE = 1;
    localparam int EN_BSCAN = 2;

    prot_lvl_e             lvl;
    logic                  erasing;
    acc_req_t              areq;
    acc_rsp_t              arsp;
    logic [NUM_DBG_EN-1:0] en;

    rdp_level_fsm #(
        .OPT_W(OPT_W), .LVL0_PAT(LVL0_PAT), .LVL1_PAT(LVL1_PAT), .LVL2_PAT(LVL2_PAT)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .opt_word_i   (opt_word_i),
        .chg_req_i    (chg_req_i),
        .chg_lvl_i    (chg_level_i),
        .erase_done_i (erase_done_i),
        .lvl_o        (lvl),
        .erasing_o    (erasing),
        .chg_ack_o    (chg_ack_o),
        .chg_err_o    (chg_err_o),
        .nv_wr_o      (nv_wr_o),
        .nv_word_o    (nv_word_o)
    );

    always_comb begin
        areq.valid    = acc_valid_i;
        areq.from_dbg = acc_dbg_i;
        areq.tgt      = acc_tgt_e'(acc_tgt_i);
        areq.op       = acc_op_e'(acc_op_i);
        areq.boot     = boot_e'(boot_mode_i);
    end

    rdp_access_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (lvl),
        .erasing_i (erasing),
        .req_i     (areq),
        .rsp_o     (arsp)
    );

    rdp_debug_enables #(.N_EN(NUM_DBG_EN)) u_en (
        .lvl_i (lvl),
        .en_o  (en)
    );

    assign acc_grant_o   = arsp.grant;
    assign acc_deny_o    = arsp.deny;
    assign acc_buserr_o  = arsp.buserr;
    assign dbg_port_en_o = en[EN_DBG];
    assign trace_en_o    = en[EN_TRACE];
    assign bscan_en_o    = en[EN_BSCAN];
    assign erase_req_o   = erasing;
    assign level_o       = lvl;

    logic opt_allowed;
    assign opt_allowed   = (lvl != LVL_LOCK) && !erasing;
    assign opt_wr_ok_o   = opt_wr_req_i && opt_allowed;
    assign opt_wr_deny_o = opt_wr_req_i && !opt_allowed;

    // R6: option words frozen at the top level and during erase
    assert_opt_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        opt_wr_ok_o |-> (level_o != 2'd2 && !erase_req_o));

    // R5: debug, trace and scan all off at the top level
    assert_lock_enables_R5: assert property (@(posedge clk) disable iff (rst)
        level_o == 2'd2 |-> !(dbg_port_en_o || trace_en_o || bscan_en_o));

    // R1: the level output only ever carries one of the three codes
    assert_level_code_R1: assert property (@(posedge clk) disable iff (rst)
        level_o != 2'd3);

endmodule

// File: tb/tb_rdp_ctrl.sv
`timescale 1ns/100ps
module tb_rdp_ctrl;

    localparam logic [7:0] P0 = 8'hAA;
    localparam logic [7:0] P1 = 8'hFF;
    localparam logic [7:0] P2 = 8'hCC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opt_word_i = P0;
    logic       chg_req_i = 0;
    logic [1:0] chg_level_i = 0;
    logic       chg_ack_o, chg_err_o, nv_wr_o, erase_req_o;
    logic [7:0] nv_word_o;
    logic       erase_done_i = 0;
    logic       acc_valid_i = 0, acc_dbg_i = 0;
    logic [1:0] acc_tgt_i = 0, acc_op_i = 0, boot_mode_i = 0;
    logic       acc_grant_o, acc_deny_o, acc_buserr_o;
    logic       opt_wr_req_i = 0, opt_wr_ok_o, opt_wr_deny_o;
    logic       dbg_port_en_o, trace_en_o, bscan_en_o;
    logic [1:0] level_o;

    always #2.5 clk = ~clk;

    rdp_ctrl dut (
        .clk(clk), .rst(rst), .opt_word_i(opt_word_i),
        .chg_req_i(chg_req_i), .chg_level_i(chg_level_i),
        .chg_ack_o(chg_ack_o), .chg_err_o(chg_err_o),
        .nv_wr_o(nv_wr_o), .nv_word_o(nv_word_o),
        .erase_req_o(erase_req_o), .erase_done_i(erase_done_i),
        .acc_valid_i(acc_valid_i), .acc_dbg_i(acc_dbg_i), .acc_tgt_i(acc_tgt_i),
        .acc_op_i(acc_op_i), .boot_mode_i(boot_mode_i),
        .acc_grant_o(acc_grant_o), .acc_deny_o(acc_deny_o), .acc_buserr_o(acc_buserr_o),
        .opt_wr_req_i(opt_wr_req_i), .opt_wr_ok_o(opt_wr_ok_o), .opt_wr_deny_o(opt_wr_deny_o),
        .dbg_port_en_o(dbg_port_en_o), .trace_en_o(trace_en_o), .bscan_en_o(bscan_en_o),
        .level_o(level_o)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done_flag = 0;
    int  m_lvl;
    bit  m_er;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int f_decode(input logic [7:0] w);
        if (w == P0) return 0;
        if (w == P2) return 2;
        return 1;
    endfunction

    function automatic logic [7:0] f_pat(input int l);
        return (l == 0) ? P0 : (l == 2) ? P2 : P1;
    endfunction

    function automatic bit f_allow(input int l, input bit er, input bit dbg,
                                   input logic [1:0] tgt, input logic [1:0] boot);
        if (er) return 0;
        if (l == 0) return 1;
        if (l == 2 && dbg) return 0;
        if (tgt <= 2'd1) return !dbg && boot == 2'd0;
        return 1;
    endfunction

    function automatic string f_acc_tag(input int l, input bit er, input bit dbg);
        if (er) return "R9";
        if (l == 0) return "R2";
        if (l == 2 && dbg) return "R5";
        return "R3";
    endfunction

    task automatic do_reset(input logic [7:0] w);
        @(negedge clk);
        rst = 1'b1; opt_word_i = w;
        chg_req_i = 0; erase_done_i = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_lvl = f_decode(w);
        m_er = 0;
        #1;
        chk("R1 level after reset", level_o, m_lvl);
        chk("R1 no erase after reset", erase_req_o, 0);
        chk("R1 no ack after reset", chg_ack_o, 0);
        chk("R1 no err after reset", chg_err_o, 0);
    endtask

    task automatic cyc(input bit req, input logic [1:0] cl, input bit done);
        bit         e_ack, e_err, e_nvw, allow, e_en, e_opt;
        int         n_lvl;
        bit         n_er;
        logic [7:0] e_word;
        string      tag;
        @(negedge clk);
        chg_req_i    = req;
        chg_level_i  = cl;
        erase_done_i = done;
        acc_valid_i  = ($urandom_range(0, 4) != 0);
        acc_dbg_i    = 1'($urandom_range(0, 1));
        acc_tgt_i    = 2'($urandom_range(0, 3));
        acc_op_i     = 2'($urandom_range(0, 3));
        boot_mode_i  = 2'($urandom_range(0, 3));
        opt_wr_req_i = 1'($urandom_range(0, 1));
        #1;
        allow = f_allow(m_lvl, m_er, acc_dbg_i, acc_tgt_i, boot_mode_i);
        tag   = f_acc_tag(m_lvl, m_er, acc_dbg_i);
        chk({tag, " grant"}, acc_grant_o, acc_valid_i && allow);
        chk({tag, " deny"}, acc_deny_o, acc_valid_i && !allow);
        chk("R4 buserr", acc_buserr_o, acc_valid_i && !allow && acc_op_i == 2'd0);
        e_en = (m_lvl != 2);
        chk("R5 enables", {dbg_port_en_o, trace_en_o, bscan_en_o}, {e_en, e_en, e_en});
        e_opt = (m_lvl != 2) && !m_er;
        chk("R6 opt ok", opt_wr_ok_o, opt_wr_req_i && e_opt);
        chk("R6 opt deny", opt_wr_deny_o, opt_wr_req_i && !e_opt);

        e_ack = 0; e_err = 0; e_nvw = 0; e_word = 8'h00;
        n_lvl = m_lvl; n_er = m_er; tag = "R11";
        if (m_er) begin
            if (req) e_err = 1;
            if (done) begin
                n_lvl = 0; n_er = 0; e_ack = 1; e_nvw = 1; e_word = P0; tag = "R8";
            end
        end else begin
            if (done && !req) tag = "R12";
            if (req) begin
                if (cl == 2'd3) e_err = 1;
                else if (m_lvl == 2) begin e_err = 1; tag = "R10"; end
                else if (int'(cl) > m_lvl) begin
                    n_lvl = int'(cl); e_ack = 1; e_nvw = 1; e_word = f_pat(n_lvl); tag = "R7";
                end else if (m_lvl == 1 && cl == 2'd0) begin
                    n_er = 1; tag = "R8";
                end else e_err = 1;
            end
        end
        @(posedge clk);
        #1;
        m_lvl = n_lvl; m_er = n_er;
        chk({tag, " level"}, level_o, m_lvl);
        chk({tag, " erase_req"}, erase_req_o, m_er);
        chk({tag, " ack"}, chg_ack_o, e_ack);
        chk({tag, " err"}, chg_err_o, e_err);
        chk({tag, " nv_wr"}, nv_wr_o, e_nvw);
        if (e_nvw) chk({tag, " nv_word"}, nv_word_o, e_word);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7));
        // R1: decode of both special patterns and corrupted words
        do_reset(P0);
        do_reset(P2);
        do_reset(8'h00);
        do_reset(8'hAB);
        // R8: regression from level 1 with a long erase
        cyc(1, 2'd0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 2'd0, 0); // R9: accesses blocked
        cyc(1, 2'd1, 0);   // R11: request during erase rejected
        cyc(0, 2'd0, 1);   // R8: commit to level 0
        cyc(0, 2'd0, 1);   // R12: stray done ignored
        cyc(1, 2'd0, 0);   // R11: same level rejected
        cyc(1, 2'd3, 0);   // R11: invalid code rejected
        cyc(1, 2'd1, 0);   // R7: raise 0 -> 1
        cyc(1, 2'd2, 0);   // R7: raise 1 -> 2
        cyc(1, 2'd0, 0);   // R10
        cyc(1, 2'd1, 0);   // R10
        cyc(0, 2'd0, 1);   // R12
        do_reset(P0);
        cyc(1, 2'd2, 0);   // R7: raise 0 -> 2 directly
        // random phase
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 39) == 0) begin
                case ($urandom_range(0, 3))
                    0: do_reset(P0);
                    1: do_reset(P2);
                    2: do_reset(P1);
                    default: do_reset(8'($urandom));
                endcase
            end
            cyc($urandom_range(0, 4) == 0, 2'($urandom_range(0, 3)),
                $urandom_range(0, 3) == 0);
        end
        finish_run();
    end

endmodule